// File: doc/BRIEF.md
# Two-key register write-protection gate

This block stands between a simple register bus and a peripheral register file. It keeps two 32-bit key registers of its own. It forwards a write strobe to the register file for a protected address only while both keys hold their exact unlock words. Writing any other word to either key, zero included, closes the gate again. The block stores none of the protected registers itself. Its outputs are a gated write strobe, a locked status flag, a one-cycle violation pulse and the read-data path.

Every address from zero up to a configurable last protected offset is protected, except the two key offsets. This range covers the time, alarm, control, status, interrupt-enable, oscillator and power-control registers. A write-one-to-clear on the status register is therefore dropped while the gate is locked. Addresses above that range pass through unchanged. Reads are never blocked. A read of a key register returns zero, so the unlock words cannot be read back.

Top module: `reg_wp_gate`

## Requirements
- R1: After reset both keys hold zero, `locked` is 1, `viol` is 0 and `rf_we` is 0.
- R2: `locked` falls one cycle after the second key receives its unlock word. The unlock words are 0x83E70B13 at offset 0x6C and 0x95A4F1E0 at offset 0x70. While only one key matches, the gate stays locked.
- R3: Writing any word other than its unlock word to either key sets `locked` to 1 from the next cycle. This includes zero and a word that differs from the unlock word in one bit.
- R4: A write to a protected address (at most 0x98 and not a key offset) raises `rf_we` in the same cycle only while `locked` is 0.
- R5: A write to a protected address while locked is dropped (`rf_we` stays 0). `viol` is then 1 for exactly the following cycle.
- R6: A write to an address above 0x98 raises `rf_we` in the same cycle whatever the lock state, and never raises `viol`.
- R7: A read of either key offset returns zero on `bus_rdata`. A read of any other address returns `rf_rdata` in the same cycle, locked or not.
- R8: A write to a key offset never raises `rf_we` and never raises `viol`.
- R9: A read (`bus_write` 0) never raises `rf_we` or `viol`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| rf_rdata | input | 32 | Read data from the register file |
| bus_rdata | output | 32 | Read data returned to the bus |
| rf_we | output | 1 | Gated write strobe to the register file |
| locked | output | 1 | 1 while the gate is closed |
| viol | output | 1 | One-cycle pulse after a dropped protected write |

## Verification
`rf_we` and `bus_rdata` are combinational and are due in the same cycle as the access. `locked` follows a key write one clock later, and `viol` follows a dropped write one clock later. The bench drives each access on the falling edge and compares all four outputs a quarter period later against a behavioural model. The model updates its key values and pending violation only at the next rising edge. As a result, every registered result is compared in the cycle after its cause, and every combinational result in the cycle of its cause.

// File: rtl/reg_wp_gate.sv
module reg_wp_gate #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] KEY0_ADDR = 8'h6C,
  parameter logic [ADDR_W-1:0] KEY1_ADDR = 8'h70,
  parameter logic [DATA_W-1:0] KEY0_WORD = 32'h83E7_0B13,
  parameter logic [DATA_W-1:0] KEY1_WORD = 32'h95A4_F1E0,
  parameter logic [ADDR_W-1:0] PROT_LAST = 8'h98
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] rf_rdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rf_we,
  output logic              locked,
  output logic              viol
);

  logic [DATA_W-1:0] key0_q, key1_q;
  logic              viol_q;

  wire wr      = bus_valid & bus_write;
  wire hit_k0  = bus_addr == KEY0_ADDR;
  wire hit_k1  = bus_addr == KEY1_ADDR;
  wire hit_key = hit_k0 | hit_k1;
  wire prot    = (bus_addr <= PROT_LAST) & ~hit_key;

  assign locked    = ~((key0_q == KEY0_WORD) & (key1_q == KEY1_WORD));
  assign rf_we     = wr & ~hit_key & (~prot | ~locked);
  assign bus_rdata = hit_key ? '0 : rf_rdata;
  assign viol      = viol_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key0_q <= '0;
      key1_q <= '0;
      viol_q <= 1'b0;
    end else begin
      if (wr & hit_k0) key0_q <= bus_wdata;
      if (wr & hit_k1) key1_q <= bus_wdata;
      viol_q <= wr & prot & locked;
    end
  end

  AST_RESET_LOCKED: assert property (@(posedge clk) !rst_n |=> locked && !viol); // R1
  AST_RELOCK_K0: assert property (@(posedge clk) disable iff (!rst_n)
    wr && hit_k0 && bus_wdata != KEY0_WORD |=> locked); // R3
  AST_RELOCK_K1: assert property (@(posedge clk) disable iff (!rst_n)
    wr && hit_k1 && bus_wdata != KEY1_WORD |=> locked); // R3
  AST_DROP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr && prot && locked |-> !rf_we ##1 viol); // R5
  AST_KEY_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    wr && hit_key |-> !rf_we ##1 !viol); // R8
  AST_READ_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_write |-> !rf_we); // R9
  AST_KEY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_write && hit_key |-> bus_rdata == '0); // R7

endmodule

// File: tb/reg_wp_gate_tb.sv
module reg_wp_gate_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] M0 = 32'h83E7_0B13;
  localparam logic [31:0] M1 = 32'h95A4_F1E0;

  logic clk = 0, rst_n = 0;
  logic bus_valid = 0, bus_write = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, rf_rdata = 0, bus_rdata;
  logic rf_we, locked, viol;

  int checks = 0, errors = 0;
  logic [31:0] m_k0 = 0, m_k1 = 0;
  bit m_viol = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reg_wp_gate u_dut (.clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rf_rdata(rf_rdata), .bus_rdata(bus_rdata),
    .rf_we(rf_we), .locked(locked), .viol(viol));

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(bit v, bit w, logic [7:0] a, logic [31:0] d, logic [31:0] rd, string tag);
    bit m_locked, prot, key, e_we;
    @(negedge clk);
    bus_valid = v; bus_write = w; bus_addr = a; bus_wdata = d; rf_rdata = rd;
    #(CLK_PERIOD/4);
    m_locked = !(m_k0 == M0 && m_k1 == M1);
    key  = (a == 8'h6C) || (a == 8'h70);
    prot = (a <= 8'h98) && !key;
    e_we = v && w && !key && (!prot || !m_locked);
    chk(tag, "locked", {31'b0, locked}, {31'b0, m_locked});
    chk(tag, "rf_we", {31'b0, rf_we}, {31'b0, e_we});
    chk(tag, "viol", {31'b0, viol}, {31'b0, m_viol});
    chk(tag, "bus_rdata", bus_rdata, key ? 32'h0 : rd);
    @(posedge clk);
    if (rst_n) begin
      if (v && w && a == 8'h6C) m_k0 = d;
      if (v && w && a == 8'h70) m_k1 = d;
      m_viol = v && w && prot && m_locked;
    end
  endtask

  initial begin
    #(CLK_PERIOD*5000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1;
    step(0, 0, 8'h00, 0, 32'h1234, "R1");
    step(1, 1, 8'h40, 32'hFF, 0, "R5");           // dropped control write
    step(1, 1, 8'h44, 32'h40, 0, "R5");           // status W1C dropped, viol from prior
    step(1, 1, 8'h6C, M0, 0, "R2");               // R8 key write
    step(1, 1, 8'h00, 32'h11, 0, "R2");           // one key only: still locked
    step(1, 1, 8'h70, M1, 0, "R8");
    step(1, 1, 8'h00, 32'h22, 0, "R4");           // unlocked now
    step(1, 1, 8'h98, 32'h1_0000, 0, "R4");
    step(1, 0, 8'h6C, 0, 32'hDEAD_BEEF, "R7");
    step(1, 0, 8'h70, 0, 32'hCAFE_F00D, "R7");
    step(1, 0, 8'h08, 0, 32'hA5A5_5A5A, "R9");
    step(1, 1, 8'h70, M1 ^ 32'h1, 0, "R3");       // one-bit-off key
    step(1, 1, 8'h10, 32'h5, 0, "R3");            // locked again, dropped
    step(1, 1, 8'h70, M1, 0, "R2");
    step(1, 1, 8'h14, 32'h7, 0, "R4");
    step(1, 1, 8'h6C, 32'h0, 0, "R3");            // zero relocks
    step(1, 1, 8'h14, 32'h7, 0, "R3");
    step(1, 1, 8'hA0, 32'h9, 0, "R6");            // unprotected passes while locked
    step(1, 1, 8'hFC, 32'h9, 0, "R6");
    step(1, 0, 8'h44, 0, 32'h0000_00C4, "R7");    // read while locked
    step(0, 1, 8'h00, 32'h1, 0, "R9");            // no valid, no strobe
    step(1, 1, 8'h70, 32'h0, 0, "R8");
    step(0, 0, 8'h00, 0, 0, "R3");
    @(negedge clk) rst_n = 0;
    m_k0 = 0; m_k1 = 0; m_viol = 0;
    @(negedge clk) rst_n = 1;
    step(0, 0, 8'h00, 0, 0, "R1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule